// File: doc/BRIEF.md
# I-Format Instruction Decoder and Control

This block is a purely combinational decoder for a 32-bit instruction word in the classic three-format RISC encoding. It slices the word into its opcode, its two register indices and its 16-bit immediate. From these it produces a 32-bit extended immediate and the control bundle that a single-cycle or pipelined datapath needs: ALU operation, second-operand select, memory read and write strobes, write-back source, register write enable, destination index and a branch-on-equal flag.

It covers the immediate arithmetic and logic group, the two compare-immediate forms, branch-on-equal, word load and word store. The register-format opcode and the two direct-jump opcodes are recognised and flagged, so a downstream PC unit and register-format decoder can take over. Any other opcode raises an illegal flag and holds every write and memory strobe low. Writes aimed at register 0 are dropped at the decoder.

The register file, the ALU, the memories and the PC logic sit outside this block. It is placed between the instruction fetch register and the operand-read stage.

Top module: `itype_decoder`

## Requirements
- R1: `imm_raw` equals instruction bits 15..0, `tgt_idx` bits 20..16, `src_idx` bits 25..21 and `op_code` bits 31..26.
- R2: `imm_ext` holds `imm_raw` in its low 16 bits. The upper 16 bits are zero for opcodes 001011 (unsigned compare), 001100 (and) and 001101 (or). For every other opcode they are copies of bit 15.
- R3: Opcodes 001000 and 001001 select ALU code 0 (add), 001010 selects 4 (signed less-than), 001011 selects 5 (unsigned less-than), 001100 selects 2 (and) and 001101 selects 3 (or). Each of them sets `alu_src_imm`, requests register write, and leaves both memory strobes and `wb_from_mem` low.
- R4: Opcode 000100 selects ALU code 1 (subtract), clears `alu_src_imm`, sets `branch_eq`, and asserts no memory strobe and no register write.
- R5: Opcode 100011 selects ALU code 0, sets `alu_src_imm`, `mem_rd` and `wb_from_mem`, requests register write, and keeps `mem_wr` low.
- R6: Opcode 101011 selects ALU code 0, sets `alu_src_imm` and `mem_wr`, and keeps `mem_rd`, `wb_from_mem` and `reg_we` low.
- R7: `wr_idx` always equals `tgt_idx`. `reg_we` is low whenever `tgt_idx` is 0, even when the opcode requests a write.
- R8: Opcode 000000 sets `rtype_flag`. Every other control output is then low and `alu_sel` is 0.
- R9: Opcodes 000010 and 000011 set `jump_flag`. Every other control output is then low and `alu_sel` is 0.
- R10: Any opcode not named in R3 to R9 sets `illegal`. `reg_we`, `mem_wr`, `mem_rd` and `branch_eq` stay low, and `alu_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_word | input | 32 | Instruction word to decode |
| op_code | output | 6 | Opcode field |
| src_idx | output | 5 | Source register index |
| tgt_idx | output | 5 | Target register index |
| imm_raw | output | 16 | Unextended immediate field |
| imm_ext | output | 32 | Sign- or zero-extended immediate |
| alu_sel | output | 4 | ALU operation code |
| alu_src_imm | output | 1 | Second ALU operand is the immediate |
| mem_rd | output | 1 | Data memory read strobe |
| mem_wr | output | 1 | Data memory write strobe |
| wb_from_mem | output | 1 | Write-back value comes from memory |
| reg_we | output | 1 | Register file write enable |
| wr_idx | output | 5 | Register file write index |
| branch_eq | output | 1 | Branch-on-equal instruction |
| jump_flag | output | 1 | Direct jump opcode, for the PC unit |
| rtype_flag | output | 1 | Register-format opcode |
| illegal | output | 1 | Opcode not recognised |

## Verification
Two functions meet in the same word in two places. A load or an ALU-immediate instruction can name register 0 as its target, so the write request and the zero-register guard collide. In the load case the memory read must still go out while the write is dropped. Directed words place a load and an add-immediate on target 0, and random words hit target 0 about one time in thirty-two. In each case the bench checks `mem_rd`, `wb_from_mem` and `reg_we` against its own model, and it checks the extension choice on immediates with bit 15 set for both the signed and the unsigned compare opcodes.

// File: rtl/itype_pkg.sv
package itype_pkg;

   localparam int OPC_W = 6;
   typedef logic [OPC_W-1:0] opc_t;

   localparam opc_t OPC_RTYPE = 6'b000000;
   localparam opc_t OPC_BEQ   = 6'b000100;
   localparam opc_t OPC_ADDI  = 6'b001000;
   localparam opc_t OPC_ADDIU = 6'b001001;
   localparam opc_t OPC_SLTI  = 6'b001010;
   localparam opc_t OPC_SLTIU = 6'b001011;
   localparam opc_t OPC_ANDI  = 6'b001100;
   localparam opc_t OPC_ORI   = 6'b001101;
   localparam opc_t OPC_LW    = 6'b100011;
   localparam opc_t OPC_SW    = 6'b101011;

   typedef enum logic [3:0] {
      ALU_ADD  = 4'd0,
      ALU_SUB  = 4'd1,
      ALU_AND  = 4'd2,
      ALU_OR   = 4'd3,
      ALU_SLT  = 4'd4,
      ALU_SLTU = 4'd5
   } alu_op_e;

   typedef struct packed {
      alu_op_e alu_sel;
      logic    alu_src_imm;
      logic    mem_rd;
      logic    mem_wr;
      logic    reg_we;
      logic    wb_from_mem;
      logic    branch_eq;
      logic    jump;
      logic    rtype;
      logic    illegal;
   } ctrl_t;

   // direct-jump opcodes share the upper five bits 00001
   function automatic logic is_jump_opc(input opc_t op);
      return op[OPC_W-1:1] == 5'b00001;
   endfunction

endpackage

// File: rtl/itype_field_split.sv
module itype_field_split #(
   parameter int INSTR_W = 32,
   parameter int OP_W    = 6,
   parameter int IDX_W   = 5,
   parameter int IMM_W   = 16
) (
   input  logic [INSTR_W-1:0] word,
   output logic [OP_W-1:0]    op,
   output logic [IDX_W-1:0]   rs,
   output logic [IDX_W-1:0]   rt,
   output logic [IMM_W-1:0]   imm
);
   localparam int IMM_LO = 0;
   localparam int RT_LO  = IMM_LO + IMM_W;
   localparam int RS_LO  = RT_LO + IDX_W;
   localparam int OP_LO  = RS_LO + IDX_W;

   if (OP_LO + OP_W != INSTR_W) begin : g_bad_layout
      $error("field widths do not fill the instruction word");
   end

   assign imm = word[IMM_LO +: IMM_W];
   assign rt  = word[RT_LO  +: IDX_W];
   assign rs  = word[RS_LO  +: IDX_W];
   assign op  = word[OP_LO  +: OP_W];
endmodule

// File: rtl/itype_imm_ext.sv
module itype_imm_ext
   import itype_pkg::*;
#(
   parameter int IMM_W      = 16,
   parameter int DATA_W     = 32,
   parameter bit LOGIC_ZEXT = 1'b1
) (
   input  opc_t              op,
   input  logic [IMM_W-1:0]  imm,
   output logic [DATA_W-1:0] ext
);
   localparam int PAD_W = DATA_W - IMM_W;

   if (PAD_W < 1) begin : g_bad_width
      $error("data width must exceed immediate width");
   end

   logic zero_sel;

   if (LOGIC_ZEXT) begin : g_logic_zext
      assign zero_sel = (op == OPC_SLTIU) | (op == OPC_ANDI) | (op == OPC_ORI);
   end else begin : g_logic_sext
      assign zero_sel = (op == OPC_SLTIU);
   end

   assign ext = zero_sel ? {{PAD_W{1'b0}}, imm}
                         : {{PAD_W{imm[IMM_W-1]}}, imm};
endmodule

// File: rtl/itype_ctrl_dec.sv
module itype_ctrl_dec
   import itype_pkg::*;
(
   input  opc_t  op,
   output ctrl_t raw
);
   always_comb begin
      raw = '0;
      raw.alu_sel = ALU_ADD;
      unique case (op)
         OPC_ADDI, OPC_ADDIU: begin
            raw.alu_src_imm = 1'b1;
            raw.reg_we      = 1'b1;
         end
         OPC_SLTI: begin
            raw.alu_sel     = ALU_SLT;
            raw.alu_src_imm = 1'b1;
            raw.reg_we      = 1'b1;
         end
         OPC_SLTIU: begin
            raw.alu_sel     = ALU_SLTU;
            raw.alu_src_imm = 1'b1;
            raw.reg_we      = 1'b1;
         end
         OPC_ANDI: begin
            raw.alu_sel     = ALU_AND;
            raw.alu_src_imm = 1'b1;
            raw.reg_we      = 1'b1;
         end
         OPC_ORI: begin
            raw.alu_sel     = ALU_OR;
            raw.alu_src_imm = 1'b1;
            raw.reg_we      = 1'b1;
         end
         OPC_BEQ: begin
            raw.alu_sel   = ALU_SUB;
            raw.branch_eq = 1'b1;
         end
         OPC_LW: begin
            raw.alu_src_imm = 1'b1;
            raw.mem_rd      = 1'b1;
            raw.wb_from_mem = 1'b1;
            raw.reg_we      = 1'b1;
         end
         OPC_SW: begin
            raw.alu_src_imm = 1'b1;
            raw.mem_wr      = 1'b1;
         end
         OPC_RTYPE: raw.rtype = 1'b1;
         default: begin
            if (is_jump_opc(op)) raw.jump    = 1'b1;
            else                 raw.illegal = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/itype_write_guard.sv
module itype_write_guard
   import itype_pkg::*;
#(
   parameter int IDX_W      = 5,
   parameter bit ZERO_GUARD = 1'b1
) (
   input  ctrl_t            raw,
   input  logic [IDX_W-1:0] tgt,
   output ctrl_t            fin
);
   logic dest_ok;

   if (ZERO_GUARD) begin : g_zero_guard
      assign dest_ok = |tgt;
   end else begin : g_no_guard
      assign dest_ok = 1'b1;
   end

   always_comb begin
      fin = raw;
      fin.reg_we = raw.reg_we & dest_ok & ~raw.illegal;
      fin.mem_wr = raw.mem_wr & ~raw.illegal;
      fin.mem_rd = raw.mem_rd & ~raw.illegal;
   end
endmodule

// File: rtl/itype_decoder.sv
module itype_decoder
   import itype_pkg::*;
#(
   parameter int INSTR_W    = 32,
   parameter int DATA_W     = 32,
   parameter int IDX_W      = 5,
   parameter int IMM_W      = 16,
   parameter bit LOGIC_ZEXT = 1'b1,
   parameter bit ZERO_GUARD = 1'b1
) (
   input  logic [INSTR_W-1:0] instr_word,
   output logic [OPC_W-1:0]   op_code,
   output logic [IDX_W-1:0]   src_idx,
   output logic [IDX_W-1:0]   tgt_idx,
   output logic [IMM_W-1:0]   imm_raw,
   output logic [DATA_W-1:0]  imm_ext,
   output logic [3:0]         alu_sel,
   output logic               alu_src_imm,
   output logic               mem_rd,
   output logic               mem_wr,
   output logic               wb_from_mem,
   output logic               reg_we,
   output logic [IDX_W-1:0]   wr_idx,
   output logic               branch_eq,
   output logic               jump_flag,
   output logic               rtype_flag,
   output logic               illegal
);
   ctrl_t ctrl_raw;
   ctrl_t ctrl_fin;

   itype_field_split #(
      .INSTR_W(INSTR_W), .OP_W(OPC_W), .IDX_W(IDX_W), .IMM_W(IMM_W)
   ) u_split (
      .word(instr_word), .op(op_code), .rs(src_idx), .rt(tgt_idx), .imm(imm_raw)
   );

   itype_imm_ext #(
      .IMM_W(IMM_W), .DATA_W(DATA_W), .LOGIC_ZEXT(LOGIC_ZEXT)
   ) u_ext (
      .op(op_code), .imm(imm_raw), .ext(imm_ext)
   );

   itype_ctrl_dec u_dec (
      .op(op_code), .raw(ctrl_raw)
   );

   itype_write_guard #(
      .IDX_W(IDX_W), .ZERO_GUARD(ZERO_GUARD)
   ) u_guard (
      .raw(ctrl_raw), .tgt(tgt_idx), .fin(ctrl_fin)
   );

   assign alu_sel     = ctrl_fin.alu_sel;
   assign alu_src_imm = ctrl_fin.alu_src_imm;
   assign mem_rd      = ctrl_fin.mem_rd;
   assign mem_wr      = ctrl_fin.mem_wr;
   assign wb_from_mem = ctrl_fin.wb_from_mem;
   assign reg_we      = ctrl_fin.reg_we;
   assign wr_idx      = tgt_idx;
   assign branch_eq   = ctrl_fin.branch_eq;
   assign jump_flag   = ctrl_fin.jump;
   assign rtype_flag  = ctrl_fin.rtype;
   assign illegal     = ctrl_fin.illegal;
endmodule

// File: rtl/itype_decoder_chk.sv
module itype_decoder_chk #(
   parameter int INSTR_W = 32,
   parameter int DATA_W  = 32,
   parameter int IDX_W   = 5,
   parameter int IMM_W   = 16
) (
   input logic [INSTR_W-1:0] instr_word,
   input logic [5:0]         op_code,
   input logic [IDX_W-1:0]   src_idx,
   input logic [IDX_W-1:0]   tgt_idx,
   input logic [IMM_W-1:0]   imm_raw,
   input logic [DATA_W-1:0]  imm_ext,
   input logic [3:0]         alu_sel,
   input logic               alu_src_imm,
   input logic               mem_rd,
   input logic               mem_wr,
   input logic               wb_from_mem,
   input logic               reg_we,
   input logic [IDX_W-1:0]   wr_idx,
   input logic               branch_eq,
   input logic               jump_flag,
   input logic               rtype_flag,
   input logic               illegal
);
   localparam int PAD_W = DATA_W - IMM_W;

   always_comb begin
      p_layout_r1: assert ({op_code, src_idx, tgt_idx, imm_raw} == instr_word)
         else $error("R1 field split mismatch");
      p_ext_r2: assert (imm_ext[IMM_W-1:0] == imm_raw &&
                        (imm_ext[DATA_W-1:IMM_W] == {PAD_W{1'b0}} ||
                         imm_ext[DATA_W-1:IMM_W] == {PAD_W{imm_raw[IMM_W-1]}}))
         else $error("R2 extension malformed");
      p_branch_r4: assert (!branch_eq || (alu_sel == 4'd1 && !alu_src_imm &&
                                          !reg_we && !mem_rd && !mem_wr))
         else $error("R4 branch controls");
      p_load_r5: assert (!mem_rd || (wb_from_mem && !mem_wr && alu_src_imm))
         else $error("R5 load controls");
      p_store_r6: assert (!mem_wr || (!reg_we && !mem_rd && alu_src_imm))
         else $error("R6 store controls");
      p_zero_dest_r7: assert (!reg_we || (wr_idx == tgt_idx && wr_idx != '0))
         else $error("R7 write to index zero");
      p_class_r8: assert ($onehot0({rtype_flag, jump_flag, illegal}))
         else $error("R8 class flags overlap");
      p_jump_r9: assert (!jump_flag || !(reg_we | mem_rd | mem_wr | branch_eq))
         else $error("R9 jump with side effects");
      p_illegal_r10: assert (!illegal || !(reg_we | mem_rd | mem_wr | branch_eq))
         else $error("R10 illegal with side effects");
   end
endmodule

bind itype_decoder itype_decoder_chk #(
   .INSTR_W(INSTR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .IMM_W(IMM_W)
) u_chk (.*);

// File: tb/tb_itype_decoder.sv
`timescale 1ns/1ps
module tb_itype_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] instr_word = '0;
   logic [5:0]  op_code;
   logic [4:0]  src_idx, tgt_idx, wr_idx;
   logic [15:0] imm_raw;
   logic [31:0] imm_ext;
   logic [3:0]  alu_sel;
   logic        alu_src_imm, mem_rd, mem_wr, wb_from_mem, reg_we;
   logic        branch_eq, jump_flag, rtype_flag, illegal;
   int          n_run = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   itype_decoder dut (
      .instr_word(instr_word), .op_code(op_code), .src_idx(src_idx),
      .tgt_idx(tgt_idx), .imm_raw(imm_raw), .imm_ext(imm_ext),
      .alu_sel(alu_sel), .alu_src_imm(alu_src_imm), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .wb_from_mem(wb_from_mem), .reg_we(reg_we),
      .wr_idx(wr_idx), .branch_eq(branch_eq), .jump_flag(jump_flag),
      .rtype_flag(rtype_flag), .illegal(illegal)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // expected controls: {alu[3:0], src_imm, mem_rd, mem_wr, wb_mem, br, jump, rtype, illegal}
   function automatic logic [11:0] exp_ctrl(input logic [5:0] op);
      case (op)
         6'b001000, 6'b001001: return {4'd0, 8'b1000_0000};
         6'b001010:            return {4'd4, 8'b1000_0000};
         6'b001011:            return {4'd5, 8'b1000_0000};
         6'b001100:            return {4'd2, 8'b1000_0000};
         6'b001101:            return {4'd3, 8'b1000_0000};
         6'b000100:            return {4'd1, 8'b0000_1000};
         6'b100011:            return {4'd0, 8'b1101_0000};
         6'b101011:            return {4'd0, 8'b1010_0000};
         6'b000000:            return {4'd0, 8'b0000_0010};
         6'b000010, 6'b000011: return {4'd0, 8'b0000_0100};
         default:              return {4'd0, 8'b0000_0001};
      endcase
   endfunction

   function automatic logic exp_we_req(input logic [5:0] op);
      return (op[5:3] == 3'b001 && op[2:1] != 2'b11) || op == 6'b100011;
   endfunction

   function automatic string class_req(input logic [5:0] op);
      if (op == 6'b000100) return "R4";
      if (op == 6'b100011) return "R5";
      if (op == 6'b101011) return "R6";
      if (op == 6'b000000) return "R8";
      if (op[5:1] == 5'b00001) return "R9";
      if (exp_we_req(op)) return "R3";
      return "R10";
   endfunction

   function automatic logic [31:0] exp_ext(input logic [31:0] w);
      logic [5:0] op = w[31:26];
      if (op == 6'b001011 || op == 6'b001100 || op == 6'b001101)
         return {16'h0000, w[15:0]};
      return {{16{w[15]}}, w[15:0]};
   endfunction

   task automatic run_word(input logic [31:0] w);
      logic [5:0] op = w[31:26];
      @(negedge clk);
      instr_word = w;
      #1;
      chk("R1", "fields", {op_code, src_idx, tgt_idx, imm_raw}, w);
      chk("R2", "imm_ext", imm_ext, exp_ext(w));
      chk(class_req(op), "controls",
          {20'd0, alu_sel, alu_src_imm, mem_rd, mem_wr, wb_from_mem,
           branch_eq, jump_flag, rtype_flag, illegal}, {20'd0, exp_ctrl(op)});
      chk("R7", "reg_we/wr_idx", {26'd0, reg_we, wr_idx},
          {26'd0, exp_we_req(op) && (w[20:16] != 5'd0), w[20:16]});
   endtask

   initial begin
      #1000000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd90517));
      repeat (2) @(posedge clk);
      #1;
      // reset state: all-zero word decodes as register format (R8)
      chk("R8", "reset rtype", {31'd0, rtype_flag}, 32'd1);
      chk("R8", "reset writes", {30'd0, reg_we, mem_wr}, 32'd0);
      rst_n = 1'b1;

      // directed corners
      run_word({6'b001000, 5'd3, 5'd0, 16'h0005});   // R7 add-imm to r0
      run_word({6'b100011, 5'd4, 5'd0, 16'hFFF0});   // R5/R7 load to r0, read kept
      run_word({6'b100011, 5'd4, 5'd9, 16'h8000});   // R5 load, negative offset
      run_word({6'b101011, 5'd1, 5'd2, 16'h7FFF});   // R6 store
      run_word({6'b001010, 5'd1, 5'd2, 16'h8000});   // R3 signed compare, sext
      run_word({6'b001011, 5'd1, 5'd2, 16'h8000});   // R2 unsigned compare, zext
      run_word({6'b001100, 5'd1, 5'd2, 16'hFFFF});   // R2 and-imm zext
      run_word({6'b001101, 5'd1, 5'd31, 16'h8001});  // R3 or-imm
      run_word({6'b001001, 5'd7, 5'd8, 16'hFFFF});   // R3 add-imm unsigned
      run_word({6'b000100, 5'd5, 5'd6, 16'hFFFE});   // R4 branch
      run_word({6'b000010, 26'h3FFFFFF});            // R9 jump
      run_word({6'b000011, 26'h0000001});            // R9 jump and link
      run_word({6'b000000, 26'h1234567});            // R8 register format
      run_word({6'b111111, 5'd1, 5'd2, 16'h0001});   // R10 illegal
      run_word({6'b010000, 5'd1, 5'd2, 16'h0001});   // R10 illegal
      run_word({6'b001110, 5'd1, 5'd2, 16'h0001});   // R10 unlisted imm opcode

      // constrained random: opcodes biased to the known set
      for (int i = 0; i < 600; i++) begin
         logic [31:0] w = $urandom;
         case ($urandom % 12)
            0:  w[31:26] = 6'b001000;
            1:  w[31:26] = 6'b001001;
            2:  w[31:26] = 6'b001010;
            3:  w[31:26] = 6'b001011;
            4:  w[31:26] = 6'b001100;
            5:  w[31:26] = 6'b001101;
            6:  w[31:26] = 6'b000100;
            7:  w[31:26] = 6'b100011;
            8:  w[31:26] = 6'b101011;
            9:  w[31:26] = {5'b00001, w[26]};
            default: ;
         endcase
         run_word(w);
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule